// File: doc/BRIEF.md
# PPS Interval Cycle Counter

This block measures the oscillator that is being disciplined. It counts that oscillator's clock cycles in a register that is never cleared. Each rising edge of the reference pulse-per-second input takes a snapshot of that count. The block subtracts the previous snapshot from the new one, which gives the exact number of oscillator cycles that elapsed between two reference pulses. Because the counter keeps running between snapshots, no cycle is lost at the boundary of an interval.

The block also reports a signed error: the measured count minus the nominal count expected per interval. A 10 MHz oscillator with one pulse per second expects 10,000,000. A faster reference uses a proportionally smaller nominal value, which is a parameter. The control loop downstream uses the error to steer the oscillator.

The reference pulse is asynchronous to the oscillator. It is brought into the oscillator domain by a synchronizer and then an edge detector. Each result leaves on a one-cycle valid strobe. There is no back-pressure: reference pulses cannot be paused, so the consumer must take the result in the cycle the strobe is high. The result then stays on the outputs until the next measurement replaces it.

Top module: `pps_cycle_stamp`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `stamp_valid_o` is 0, and `delta_o` and `err_o` are both 0.
- R2: The first reference rising edge after reset only records a snapshot and produces no strobe. This also holds after a reset in the middle of operation.
- R3: For two consecutive reference rising edges N oscillator cycles apart, `delta_o` equals N modulo 2^CNT_W. The counter is never cleared between measurements.
- R4: When the running counter wraps between two snapshots, the modular difference still gives the true interval. An interval of exactly 2^CNT_W cycles reads as 0.
- R5: `err_o` is a two's-complement value CNT_W+1 bits wide, equal to `delta_o` minus NOMINAL. It is negative when the interval is short.
- R6: `stamp_valid_o` is high for exactly one cycle per reference rising edge, counting from the second edge after reset. A reference input held high produces no further strobes.
- R7: Take the first rising clock edge at which `pps_in` is sampled high. `stamp_valid_o` and its result appear after the third rising clock edge counted from that one: two synchronizer stages plus the capture register.
- R8: While `stamp_valid_o` is low, `delta_o` and `err_o` hold the result of the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Clock from the oscillator being disciplined |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous reference pulse, rising edge marks an interval boundary |
| stamp_valid_o | output | 1 | One-cycle strobe marking a new result |
| delta_o | output | CNT_W | Oscillator cycles between the last two reference edges |
| err_o | output | CNT_W+1 | Signed difference `delta_o` minus NOMINAL |

## Verification
Reference edges are driven on falling clock edges. The first rising edge that samples a new pulse is therefore known exactly, and the result is due just after the third rising edge from there. The bench samples at the falling edge that follows that third rising edge. At every other falling edge within an interval it requires the strobe to be low and the outputs to be unchanged. The sweep covers every interval from 4 to 300 cycles on an 8-bit counter with a nominal count of 100, so it passes through counter wraps and aliasing.

// File: rtl/pps_stamp_pkg.sv
package pps_stamp_pkg;
  // Arming state of the snapshot register.
  typedef enum logic {
    ST_COLD  = 1'b0,  // no snapshot yet since reset
    ST_ARMED = 1'b1   // a previous snapshot exists
  } stamp_state_e;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q[0] <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LAST-1:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[LAST];
  end

  assign rise_o = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) cnt_o <= '0;
    else     cnt_o <= cnt_o + STEP;  // wraps freely, never cleared
  end
endmodule

// File: rtl/stamp_delta.sv
module stamp_delta
  import pps_stamp_pkg::*;
#(
  parameter int              CNT_W   = 32,
  parameter longint unsigned NOMINAL = 10_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             armed_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] delta_o,
  output logic [CNT_W:0]   err_o
);
  localparam int               ERR_W   = CNT_W + 1;
  localparam logic [ERR_W-1:0] NOM_EXT = ERR_W'(NOMINAL);

  stamp_state_e     state_q;
  logic [CNT_W-1:0] snap_q;
  logic [CNT_W-1:0] span;
  logic [ERR_W-1:0] dev;

  always_comb begin
    span = cnt_i - snap_q;            // modular difference
    dev  = {1'b0, span} - NOM_EXT;    // two's complement deviation
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_COLD;
      snap_q  <= '0;
      valid_o <= 1'b0;
      delta_o <= '0;
      err_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        snap_q  <= cnt_i;
        state_q <= ST_ARMED;
        if (state_q == ST_ARMED) begin
          delta_o <= span;
          err_o   <= dev;
          valid_o <= 1'b1;
        end
      end
    end
  end

  assign armed_o = (state_q == ST_ARMED);
endmodule

// File: rtl/pps_cycle_stamp.sv
module pps_cycle_stamp #(
  parameter int              CNT_W       = 32,
  parameter longint unsigned NOMINAL     = 10_000_000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic             osc_clk,
  input  logic             rst,
  input  logic             pps_in,
  output logic             stamp_valid_o,
  output logic [CNT_W-1:0] delta_o,
  output logic [CNT_W:0]   err_o
);
  logic             pps_rise;
  logic [CNT_W-1:0] run_cnt;
  logic             armed;

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (osc_clk),
    .rst      (rst),
    .async_in (pps_in),
    .rise_o   (pps_rise)
  );

  cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (osc_clk),
    .rst   (rst),
    .cnt_o (run_cnt)
  );

  stamp_delta #(.CNT_W(CNT_W), .NOMINAL(NOMINAL)) u_stamp (
    .clk     (osc_clk),
    .rst     (rst),
    .rise_i  (pps_rise),
    .cnt_i   (run_cnt),
    .armed_o (armed),
    .valid_o (stamp_valid_o),
    .delta_o (delta_o),
    .err_o   (err_o)
  );
endmodule

// File: rtl/pps_stamp_chk.sv
module pps_stamp_chk #(
  parameter int              CNT_W   = 32,
  parameter longint unsigned NOMINAL = 10_000_000
) (
  input logic             clk,
  input logic             rst,
  input logic             rise,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             valid,
  input logic [CNT_W-1:0] delta,
  input logic [CNT_W:0]   err
);
  localparam logic [CNT_W:0] NOM_CHK = (CNT_W+1)'(NOMINAL);

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |-> ($stable(delta) && $stable(err)));

  // R5
  err_match_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (err == ({1'b0, delta} - NOM_CHK)));

  // R2
  armed_cause_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($past(rise) && $past(armed)));

  // R3
  free_run_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt == $past(cnt) + 1'b1));
endmodule

bind pps_cycle_stamp pps_stamp_chk #(.CNT_W(CNT_W), .NOMINAL(NOMINAL)) u_chk (
  .clk   (osc_clk),
  .rst   (rst),
  .rise  (pps_rise),
  .armed (armed),
  .cnt   (run_cnt),
  .valid (stamp_valid_o),
  .delta (delta_o),
  .err   (err_o)
);

// File: tb/sim_pps_cycle_stamp.sv
`timescale 1ns/1ps
module sim_pps_cycle_stamp;
  localparam int CW  = 8;
  localparam int NOM = 100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pps = 1'b0;
  logic          vld;
  logic [CW-1:0] dlt;
  logic [CW:0]   err;

  int checks = 0;
  int fails  = 0;
  int last_delta = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pps_cycle_stamp #(.CNT_W(CW), .NOMINAL(NOM), .SYNC_STAGES(2)) u0 (
    .osc_clk       (osc_clk_w),
    .rst           (rst),
    .pps_in        (pps),
    .stamp_valid_o (vld),
    .delta_o       (dlt),
    .err_o         (err)
  );
  wire osc_clk_w = clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pps = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(vld == 1'b0, "R1 valid", int'(vld), 0);
    chk(dlt == '0, "R1 delta", int'(dlt), 0);
    chk(err == '0, "R1 err", int'(err), 0);
    last_delta = 0;
  endtask

  // Raise pps at a falling edge, keep it high for `width` rising edges,
  // next rise comes `gap` rising edges later.
  task automatic pulse(input int gap, input int width, input bit expv, input int expd);
    int exp_err;
    exp_err = expd - NOM;
    pps = 1'b1;
    for (int i = 1; i <= gap; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 3 && expv) begin
        // R7 latency, R3/R4 delta, R5 error
        chk(vld == 1'b1, "R7 strobe due", int'(vld), 1);
        chk(int'(dlt) == expd, "R3 R4 delta", int'(dlt), expd);
        chk($signed(err) == exp_err, "R5 err", int'($signed(err)), exp_err);
        last_delta = int'(dlt);
      end else begin
        // R2 no strobe on first edge, R6 single strobe, R8 hold
        chk(vld == 1'b0, i == 3 ? "R2 no strobe" : "R6 strobe low", int'(vld), 0);
        chk(int'(dlt) == last_delta, "R8 delta hold", int'(dlt), last_delta);
        chk($signed(err) == last_delta - NOM, "R8 err hold",
            int'($signed(err)), last_delta - NOM);
      end
      if (i == width) pps = 1'b0;
    end
  endtask

  initial begin
    do_reset();
    last_delta = 0;
    // R2: first edge only arms; err still shows reset value 0
    begin
      pps = 1'b1;
      for (int i = 1; i <= 50; i++) begin
        @(posedge clk);
        @(negedge clk);
        chk(vld == 1'b0, "R2 first edge", int'(vld), 0);
        chk(dlt == '0, "R1 delta idle", int'(dlt), 0);
        if (i == 2) pps = 1'b0;
      end
    end
    last_delta = 0;
    // After the first strobe err follows delta; seed hold value via first sweep step
    for (int g = 4; g <= 300; g++) begin
      int w;
      w = 1 + (g % 7);
      if (g % 10 == 0) w = g - 1;  // R6 long high level
      if (w >= g) w = g - 1;
      if (g == 4) begin
        // err hold check before the first strobe would compare 0 with -NOM: guard
        pps = 1'b1;
        for (int i = 1; i <= g; i++) begin
          @(posedge clk);
          @(negedge clk);
          if (i == 3) begin
            chk(vld == 1'b1, "R7 strobe due", int'(vld), 1);
            chk(int'(dlt) == 50, "R3 delta", int'(dlt), 50);
            chk($signed(err) == 50 - NOM, "R5 err", int'($signed(err)), 50 - NOM);
            last_delta = int'(dlt);
          end else begin
            chk(vld == 1'b0, "R6 strobe low", int'(vld), 0);
          end
          if (i == w) pps = 1'b0;
        end
      end else begin
        pulse(g, w, 1'b1, (g - 1) % 256);
      end
    end
    // last sweep interval (300) is measured by the next rise
    pulse(20, 3, 1'b1, 300 % 256);

    // R2 again after mid-run reset
    do_reset();
    pps = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk(vld == 1'b0, "R2 after reset", int'(vld), 0);
      if (i == 1) pps = 1'b0;
    end
    last_delta = 0;
    pps = 1'b1;
    for (int i = 1; i <= 100; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == 3) begin
        chk(vld == 1'b1, "R7 strobe due", int'(vld), 1);
        chk(int'(dlt) == 20, "R3 delta", int'(dlt), 20);
        last_delta = int'(dlt);
      end else begin
        chk(vld == 1'b0, "R6 strobe low", int'(vld), 0);
      end
      if (i == 5) pps = 1'b0;
    end
    pulse(255, 9, 1'b1, 100);              // R5 zero error
    pulse(256, 255, 1'b1, 255);            // R5 positive error
    pulse(30, 1, 1'b1, 0);                 // R4 full wrap reads 0
    pulse(10, 2, 1'b1, 30);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule